// File: doc/BRIEF.md
# Recursive Half-Split Unsigned Multiplier

This block multiplies two unsigned operands of equal width and returns the full double-width product. It never builds a flat partial-product array. Each operand is cut into an upper and a lower half of equal width. Four multipliers of half the width form the cross products of those halves. Two adders then merge the shifted cross products into the result. This split repeats through a generate recursion until the pieces are two bits wide. At that point a leaf cell forms each result column from the crosswise bit products whose indices add up to that column, and ripples the column carries upward.

The arithmetic core has no state. A parameter adds one output register stage, with a valid flag that follows the input valid one clock later. A held product stays unchanged while no new operand pair is presented. Set the parameter to zero and the product and valid pass straight through.

Top module: `vmul_top`

## Requirements
- R1: For any operands `a` and `b` presented with `in_valid` high, `product` equals the unsigned product a×b over the full 2×WIDTH bits.
- R2: With OUT_REG=1, `product` and `out_valid`=1 appear one clock edge after the edge at which `in_valid` was sampled high.
- R3: With OUT_REG=1, `out_valid` is 0 after any edge at which `in_valid` was sampled low.
- R4: With OUT_REG=1, `product` keeps its value across an edge at which `in_valid` is low, even when `a` and `b` change.
- R5: With OUT_REG=1, an edge with the synchronous active-high `rst` high sets `out_valid` to 0 and `product` to 0, regardless of `in_valid`.
- R6: A zero operand on either side yields a zero product.
- R7: Two all-ones operands yield 2^(2W) − 2^(W+1) + 1.
- R8: An operand equal to 1 yields the other operand, zero-extended.
- R9: At WIDTH=2 the leaf cell alone produces the correct 4-bit product for all 16 operand pairs.
- R10: With OUT_REG=0, `product` equals a×b and `out_valid` equals `in_valid` in the same cycle, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| in_valid | input | 1 | Marks `a` and `b` as a pair to multiply |
| a | input | WIDTH | Unsigned multiplicand |
| b | input | WIDTH | Unsigned multiplier |
| out_valid | output | 1 | Marks `product` as a fresh result |
| product | output | 2*WIDTH | Unsigned double-width product |

## Verification
On every clock the assertions check three things. Each captured product matches the product of the operands sampled one edge before. The valid flag drops after an idle edge. The held product stays stable while idle. Reset clears both outputs, and in pass-through mode product and valid follow their inputs at once. The bench scenarios cover what a cycle-local rule cannot choose for itself. These are the arithmetic corner values (zero, all ones, identity), the exhaustive leaf case at width two, and the random sweeps at several widths that reach every branch of the recursion.

// File: rtl/vmul_pkg.sv
package vmul_pkg;
  // Width at which the recursion stops and the crosswise leaf cell is used
  localparam int LEAF_W = 2;
endpackage

// File: rtl/vmul_leaf2.sv
module vmul_leaf2 (
  input  logic [1:0] a,
  input  logic [1:0] b,
  output logic [3:0] p
);
  logic [1:0] col1;
  logic [1:0] col2;

  always_comb begin
    // column 1: crosswise products whose bit indices sum to 1
    col1 = {1'b0, a[1] & b[0]} + {1'b0, a[0] & b[1]};
    // column 2: vertical product of the upper bits plus carry from column 1
    col2 = {1'b0, a[1] & b[1]} + {1'b0, col1[1]};
    p    = {col2, col1[0], a[0] & b[0]};
  end
endmodule

// File: rtl/vmul_combine.sv
module vmul_combine #(
  parameter int W = 4
) (
  input  logic [W-1:0]   p_ll,
  input  logic [W-1:0]   p_lh,
  input  logic [W-1:0]   p_hl,
  input  logic [W-1:0]   p_hh,
  output logic [2*W-1:0] p
);
  localparam int H = W / 2;

  logic [W:0]     mid;
  logic [2*W-1:0] mid_sh;

  always_comb begin
    // W-bit adder for the two cross terms, then the 2W-bit merge
    mid    = {1'b0, p_lh} + {1'b0, p_hl};
    mid_sh = {{(W-1){1'b0}}, mid} << H;
    p      = {p_hh, p_ll} + mid_sh;
  end
endmodule

// File: rtl/vmul_node.sv
module vmul_node
  import vmul_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] p
);
  localparam int H = W / 2;

  generate
    if (W <= LEAF_W) begin : g_leaf
      vmul_leaf2 u_leaf (.a(a), .b(b), .p(p));
    end else begin : g_split
      logic [W-1:0] p_ll, p_lh, p_hl, p_hh;

      vmul_node #(.W(H)) u_ll (.a(a[H-1:0]), .b(b[H-1:0]), .p(p_ll));
      vmul_node #(.W(H)) u_lh (.a(a[H-1:0]), .b(b[W-1:H]), .p(p_lh));
      vmul_node #(.W(H)) u_hl (.a(a[W-1:H]), .b(b[H-1:0]), .p(p_hl));
      vmul_node #(.W(H)) u_hh (.a(a[W-1:H]), .b(b[W-1:H]), .p(p_hh));

      vmul_combine #(.W(W)) u_cmb (
        .p_ll(p_ll), .p_lh(p_lh), .p_hl(p_hl), .p_hh(p_hh), .p(p)
      );
    end
  endgenerate
endmodule

// File: rtl/vmul_top.sv
module vmul_top #(
  parameter int WIDTH   = 64,
  parameter int OUT_REG = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [WIDTH-1:0]   a,
  input  logic [WIDTH-1:0]   b,
  output logic               out_valid,
  output logic [2*WIDTH-1:0] product
);
  localparam int PW = 2 * WIDTH;

  logic [PW-1:0] prod_c;

  vmul_node #(.W(WIDTH)) u_core (.a(a), .b(b), .p(prod_c));

  generate
    if (OUT_REG != 0) begin : g_reg
      logic          vld_q;
      logic [PW-1:0] prod_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          vld_q  <= 1'b0;
          prod_q <= '0;
        end else begin
          vld_q <= in_valid;
          if (in_valid) prod_q <= prod_c;
        end
      end

      assign out_valid = vld_q;
      assign product   = prod_q;
    end else begin : g_comb
      assign out_valid = in_valid;
      assign product   = prod_c;
    end
  endgenerate
endmodule

// File: rtl/vmul_top_chk.sv
module vmul_top_chk #(
  parameter int WIDTH   = 64,
  parameter int OUT_REG = 1
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic [WIDTH-1:0]   a,
  input logic [WIDTH-1:0]   b,
  input logic               out_valid,
  input logic [2*WIDTH-1:0] product
);
  logic [2*WIDTH-1:0] a_ext, b_ext, ref_prod;
  assign a_ext    = {{WIDTH{1'b0}}, a};
  assign b_ext    = {{WIDTH{1'b0}}, b};
  assign ref_prod = a_ext * b_ext;

  generate
    if (OUT_REG != 0) begin : g_reg_chk
      logic rst_seen;
      always_ff @(posedge clk) rst_seen <= rst;

      // R1 R2
      lat_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_valid && product == $past(ref_prod)));

      // R3
      valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

      // R4
      hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(product));

      // R5
      always @(negedge clk) begin
        if (rst_seen === 1'b1) begin
          rst_clear_chk: assert (!out_valid && product == '0);
        end
      end
    end else begin : g_comb_chk
      // R10
      always @(negedge clk) begin
        comb_match_chk: assert (out_valid == in_valid && product == ref_prod);
      end
    end
  endgenerate
endmodule

bind vmul_top vmul_top_chk #(.WIDTH(WIDTH), .OUT_REG(OUT_REG)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .a(a), .b(b),
  .out_valid(out_valid), .product(product)
);

// File: tb/vmul_top_tb.sv
module vmul_top_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  // 64-bit registered instance
  logic         vld64 = 1'b0;
  logic [63:0]  a64 = '0, b64 = '0;
  logic         ov64;
  logic [127:0] p64;
  vmul_top #(.WIDTH(64), .OUT_REG(1)) u_dut (
    .clk(clk), .rst(rst), .in_valid(vld64), .a(a64), .b(b64),
    .out_valid(ov64), .product(p64));

  // 2-bit pass-through instance (leaf only)
  logic       vld2 = 1'b0;
  logic [1:0] a2 = '0, b2 = '0;
  logic       ov2;
  logic [3:0] p2;
  vmul_top #(.WIDTH(2), .OUT_REG(0)) u_w2 (
    .clk(clk), .rst(rst), .in_valid(vld2), .a(a2), .b(b2),
    .out_valid(ov2), .product(p2));

  // 16-bit pass-through instance
  logic        vld16 = 1'b0;
  logic [15:0] a16 = '0, b16 = '0;
  logic        ov16;
  logic [31:0] p16;
  vmul_top #(.WIDTH(16), .OUT_REG(0)) u_w16 (
    .clk(clk), .rst(rst), .in_valid(vld16), .a(a16), .b(b16),
    .out_valid(ov16), .product(p16));

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drives one pair into the registered instance and checks the result one edge later
  task automatic mul64(input string req, input logic [63:0] x, input logic [63:0] y);
    logic [127:0] exp;
    exp = {64'd0, x} * {64'd0, y};
    @(negedge clk);
    a64 = x; b64 = y; vld64 = 1'b1;
    @(negedge clk);
    vld64 = 1'b0;
    check({req, " product"}, p64, exp);
    check({req, " R2 valid"}, {127'd0, ov64}, 128'd1);
  endtask

  task automatic t_reset();
    // R5: reset with a live input still clears the outputs
    @(negedge clk);
    rst = 1'b1; vld64 = 1'b1; a64 = 64'd7; b64 = 64'd9;
    @(negedge clk);
    check("R5 valid", {127'd0, ov64}, 128'd0);
    check("R5 product", p64, 128'd0);
    vld64 = 1'b0;
    rst = 1'b0;
  endtask

  task automatic t_corners();
    logic [63:0] ones;
    ones = '1;
    mul64("R6 zero a", 64'd0, 64'h1234_5678_9abc_def0);
    mul64("R6 zero b", 64'hfedc_ba98_7654_3210, 64'd0);
    mul64("R7 all ones", ones, ones);
    check("R7 closed form", p64, 128'd0 - (128'd1 << 65) + 128'd1);
    mul64("R8 identity", 64'd1, 64'hdead_beef_cafe_f00d);
    check("R8 value", p64, {64'd0, 64'hdead_beef_cafe_f00d});
  endtask

  task automatic t_random64();
    for (int i = 0; i < 40; i++) begin
      mul64("R1 random", {$urandom, $urandom}, {$urandom, $urandom});
    end
    // pairs hitting only the upper or lower halves
    mul64("R1 upper halves", 64'hffff_ffff_0000_0000, 64'h8000_0001_0000_0000);
    mul64("R1 lower halves", 64'h0000_0000_ffff_ffff, 64'h0000_0000_ffff_ffff);
  endtask

  task automatic t_idle();
    logic [127:0] held;
    mul64("R2 seed", 64'h0123_4567_89ab_cdef, 64'h0f0f_0f0f_0f0f_0f0f);
    held = p64;
    // inputs change while in_valid stays low
    a64 = 64'hffff_0000_ffff_0000; b64 = 64'h1111_2222_3333_4444;
    @(negedge clk);
    check("R3 valid low", {127'd0, ov64}, 128'd0);
    check("R4 held", p64, held);
    @(negedge clk);
    check("R4 held again", p64, held);
  endtask

  task automatic t_leaf();
    // R9: exhaustive 2x2
    vld2 = 1'b1;
    for (int x = 0; x < 4; x++) begin
      for (int y = 0; y < 4; y++) begin
        a2 = 2'(x); b2 = 2'(y);
        #1;
        check("R9 leaf", {124'd0, p2}, 128'(x * y));
      end
    end
    vld2 = 1'b0;
    #1;
    check("R10 w2 valid", {127'd0, ov2}, 128'd0);
  endtask

  task automatic t_comb16();
    logic [31:0] exp;
    vld16 = 1'b1;
    for (int i = 0; i < 30; i++) begin
      a16 = 16'($urandom); b16 = 16'($urandom);
      exp = {16'd0, a16} * {16'd0, b16};
      #1;
      check("R10 w16 product", {96'd0, p16}, {96'd0, exp});
      check("R10 w16 valid", {127'd0, ov16}, 128'd1);
    end
    a16 = 16'hffff; b16 = 16'hffff;
    #1;
    check("R7 w16 all ones", {96'd0, p16}, {96'd0, 32'hfffe_0001});
    a16 = 16'h0000; b16 = 16'hbeef;
    #1;
    check("R6 w16 zero", {96'd0, p16}, 128'd0);
    vld16 = 1'b0;
    #1;
    check("R10 w16 valid low", {127'd0, ov16}, 128'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_corners();
    t_random64();
    t_idle();
    t_leaf();
    t_comb16();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule